// File: doc/BRIEF.md
# MDIO Management Frame Controller

This block lets a host reach the management registers of an external Ethernet PHY over the two-wire MDC/MDIO bus. The host sees two 32-bit registers, picked by a one-bit select. The command register holds the target PHY address, the PHY register number, a direction flag and a busy flag. The data register holds a 16-bit value.

A single write to the command register launches one complete management frame. MDC is produced by dividing the system clock. MDIO is shifted out MSB first, with each bit held for one full MDC period.

For a write, the host loads the data register first and then issues the command. For a read, the controller releases MDIO for the turnaround and data bits. It captures the 16 bits the PHY drives and makes them visible in the data register when busy drops. Only one operation is in flight at a time. The host polls busy before it issues the next command.

Top module: `mdio_mgmt_ctrl`

## Requirements
- R1: After reset both registers read as zero, MDC is low and the MDIO output enable is low.
- R2: The command register reads back the PHY address in bits 15:11, the register number in bits 10:6, the direction in bit 1 (1 = write, 0 = read) and busy in bit 0, with all other bits zero.
- R3: A command write accepted while idle sets busy from the next cycle on. Busy stays set for exactly 128*DIV_HALF clock cycles.
- R4: During a frame, each of the 64 bits spans DIV_HALF cycles with MDC low followed by DIV_HALF cycles with MDC high. MDC is low while idle.
- R5: A write frame drives, MSB first, 32 ones, start 01, opcode 01, the 5-bit PHY address, the 5-bit register number, turnaround 10 and the 16 data bits. MDIO changes only when MDC falls.
- R6: A read frame uses opcode 10. The MDIO output enable is low for bits 46 to 63 (turnaround and data) and high for bits 0 to 45.
- R7: In a read, MDIO input is sampled at the rising MDC edge of bits 48 to 63, MSB first. The 16-bit result appears in the data register when busy clears, and the register keeps its old value until then.
- R8: A command write while busy is ignored. The fields and the frame in progress are unaffected.
- R9: A data register write while busy is ignored.
- R10: The data register keeps only the low 16 bits of a write. Its upper 16 bits read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | Register select: 0 command, 1 data |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the selected register |
| mdc | output | 1 | Management clock to the PHY |
| mdio_out | output | 1 | MDIO value driven by the controller |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_in | input | 1 | MDIO value seen on the line |

## Verification
The bench builds the controller with DIV_HALF = 3. This odd, non-power-of-two half period exercises the divider wrap away from a binary boundary, while keeping a full 64-bit frame to 384 cycles. That makes several complete write and read frames affordable, each with every MDC edge, output enable transition and capture point compared. It also leaves room to issue ignored command and data writes in the middle of frames and to watch both registers across the busy-to-idle edge.

// File: rtl/mdio_mgmt_ctrl.sv
module mdio_mgmt_ctrl #(
  parameter int DIV_HALF = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic        reg_sel,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        mdc,
  output logic        mdio_out,
  output logic        mdio_oe,
  input  logic        mdio_in
);
  localparam int HW = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;
  localparam logic [5:0] LAST_BIT = 6'd63;
  localparam logic [5:0] TA_BIT   = 6'd46;
  localparam logic [5:0] DATA_BIT = 6'd48;

  logic          busy, wr_q, mdc_q;
  logic [4:0]    phy_q, reg_q;
  logic [15:0]   data_q, cap_q;
  logic [HW-1:0] half_cnt;
  logic [5:0]    bit_idx;

  wire half_end = (half_cnt == HW'(DIV_HALF - 1));
  wire cmd_go   = reg_wr && !reg_sel && !busy;
  wire unused_wdata = ^{reg_wdata[31:16], reg_wdata[5:2], reg_wdata[0]};

  wire [63:0] frame = {32'hFFFF_FFFF, 2'b01, (wr_q ? 2'b01 : 2'b10),
                       phy_q, reg_q, 2'b10, data_q};

  assign mdc       = mdc_q;
  assign mdio_out  = busy ? frame[LAST_BIT - bit_idx] : 1'b1;
  assign mdio_oe   = busy && (wr_q || bit_idx < TA_BIT);
  assign reg_rdata = reg_sel ? {16'h0, data_q}
                             : {16'h0, phy_q, reg_q, 4'h0, wr_q, busy};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      wr_q     <= 1'b0;
      mdc_q    <= 1'b0;
      phy_q    <= '0;
      reg_q    <= '0;
      data_q   <= '0;
      cap_q    <= '0;
      half_cnt <= '0;
      bit_idx  <= '0;
    end else if (cmd_go) begin
      phy_q    <= reg_wdata[15:11];
      reg_q    <= reg_wdata[10:6];
      wr_q     <= reg_wdata[1];
      busy     <= 1'b1;
      bit_idx  <= '0;
      half_cnt <= '0;
      mdc_q    <= 1'b0;
    end else if (busy) begin
      if (!half_end) begin
        half_cnt <= half_cnt + 1'b1;
      end else begin
        half_cnt <= '0;
        mdc_q    <= !mdc_q;
        if (!mdc_q) begin
          if (!wr_q && bit_idx >= DATA_BIT) cap_q <= {cap_q[14:0], mdio_in};
        end else if (bit_idx == LAST_BIT) begin
          busy <= 1'b0;
          if (!wr_q) data_q <= cap_q;
        end else begin
          bit_idx <= bit_idx + 1'b1;
        end
      end
    end else if (reg_wr && reg_sel) begin
      data_q <= reg_wdata[15:0];
    end
  end

  p_busy_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !reg_sel && !busy) |=> busy);

  p_mdc_idle_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !cmd_go) |=> !mdc);

  p_mdo_hold_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && mdc && !half_end) |=> $stable(mdio_out));

  p_ignore_cmd_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && reg_wr && !reg_sel) |=> ($stable(phy_q) && $stable(reg_q) && $stable(wr_q)));

  p_ignore_data_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr_q && reg_wr && reg_sel) |=> $stable(data_q));

  p_read_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !wr_q && !(mdc && half_end && bit_idx == LAST_BIT)) |=> $stable(data_q));
endmodule

// File: tb/tb_mdio_mgmt_ctrl.sv
`timescale 1ns/100ps
module tb_mdio_mgmt_ctrl;
  localparam int D = 3;
  localparam int FRAME_CYC = 128 * D;

  logic clk = 1'b0, rst_n = 1'b0, reg_wr = 1'b0, reg_sel = 1'b0, mdio_in = 1'b1;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic mdc, mdio_out, mdio_oe;

  mdio_mgmt_ctrl #(.DIV_HALF(D)) dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
    .mdio_out(mdio_out), .mdio_oe(mdio_oe), .mdio_in(mdio_in));

  always #2.5 clk = ~clk;

  int n_cmp = 0, n_bad = 0;
  bit m_busy = 0, m_wr = 0;
  int m_t = 0;
  logic [4:0] m_phy = '0, m_reg = '0;
  logic [15:0] m_data = '0, phy_val = '0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic int cur_bit();
    return m_t / (2 * D);
  endfunction

  function automatic logic exp_bit();
    logic [63:0] f;
    f = {32'hFFFF_FFFF, 2'b01, (m_wr ? 2'b01 : 2'b10), m_phy, m_reg, 2'b10, m_data};
    return f[63 - cur_bit()];
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_wr = 0; m_t = 0; m_phy = '0; m_reg = '0; m_data = '0;
    end else if (m_busy) begin
      m_t++;
      if (m_t == FRAME_CYC) begin
        m_busy = 0;
        if (!m_wr) m_data = phy_val;
      end
    end else if (reg_wr) begin
      if (!reg_sel) begin
        m_busy = 1; m_t = 0;
        m_phy = reg_wdata[15:11]; m_reg = reg_wdata[10:6]; m_wr = reg_wdata[1];
      end else m_data = reg_wdata[15:0];
    end
    #1;
    if (rst_n) begin
      chk("R2/R10 readback", reg_rdata, reg_sel ? {16'h0, m_data}
          : {16'h0, m_phy, m_reg, 4'h0, m_wr, m_busy});
      chk("R4 mdc", {31'h0, mdc}, {31'h0, m_busy && ((m_t % (2 * D)) >= D)});
      chk("R6 oe", {31'h0, mdio_oe}, {31'h0, m_busy && (m_wr || cur_bit() < 46)});
      if (m_busy && mdio_oe) chk("R5 mdio_out", {31'h0, mdio_out}, {31'h0, exp_bit()});
    end
  end

  always @(negedge clk) begin
    if (m_busy && !m_wr && cur_bit() >= 48) mdio_in = phy_val[15 - (cur_bit() - 48)];
    else mdio_in = 1'b1;
  end

  task automatic wr_reg(logic sel, logic [31:0] val);
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = sel; reg_wdata = val;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (m_busy) @(negedge clk);
  endtask

  function automatic logic [31:0] cmd(logic [4:0] p, logic [4:0] r, logic w);
    return {16'h0, p, r, 4'h0, w, 1'b0};
  endfunction

  bit done = 0;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1 cmd reset", reg_rdata, 32'h0);
    chk("R1 mdc/oe reset", {30'h0, mdc, mdio_oe}, 32'h0);
    @(negedge clk); reg_sel = 1'b1; #1;
    chk("R1 data reset", reg_rdata, 32'h0);

    wr_reg(1'b1, 32'hDEAD_A5C3);
    #1; chk("R10 upper dropped", reg_rdata, 32'h0000_A5C3);
    wr_reg(1'b0, cmd(5'h11, 5'h0A, 1'b1));
    reg_sel = 1'b0; #1;
    chk("R3 busy set", reg_rdata, {16'h0, 5'h11, 5'h0A, 4'h0, 1'b1, 1'b1});
    repeat (40) @(negedge clk);
    wr_reg(1'b0, cmd(5'h02, 5'h1F, 1'b0));
    #1; chk("R8 ignored cmd", reg_rdata, {16'h0, 5'h11, 5'h0A, 4'h0, 1'b1, 1'b1});
    wr_reg(1'b1, 32'h0000_1111);
    reg_sel = 1'b1; #1;
    chk("R9 ignored data", reg_rdata, 32'h0000_A5C3);
    wait_idle();
    reg_sel = 1'b0; #1;
    chk("R3 busy cleared", {31'h0, reg_rdata[0]}, 32'h0);

    phy_val = 16'hBEEF;
    wr_reg(1'b0, cmd(5'h01, 5'h02, 1'b0));
    reg_sel = 1'b1;
    repeat (300) @(negedge clk);
    #1; chk("R7 data held mid-read", reg_rdata, 32'h0000_A5C3);
    wait_idle();
    #1; chk("R7 read result", reg_rdata, 32'h0000_BEEF);

    phy_val = 16'h8001;
    reg_sel = 1'b0;
    wr_reg(1'b0, cmd(5'h1F, 5'h1F, 1'b0));
    wait_idle();
    reg_sel = 1'b1; #1;
    chk("R7 read edge bits", reg_rdata, 32'h0000_8001);

    wr_reg(1'b1, 32'hFFFF_0000);
    reg_sel = 1'b0;
    wr_reg(1'b0, cmd(5'h00, 5'h00, 1'b1));
    wait_idle();
    #1; chk("R2 final cmd", reg_rdata, {16'h0, 10'h0, 4'h0, 1'b1, 1'b0});
    repeat (4) @(negedge clk);
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(100000 * 5);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule